// File: doc/BRIEF.md
# Address-Keyed Serial Clock Register Port

This block sits between a boot-ROM socket and the system bus. Its job is to hide an 8-byte clock register file behind what look like ordinary ROM reads. The block watches each chip-selected access and decodes it from the address lines alone. Address bit 2 low marks a write, and address bit 0 then supplies the write data bit. Address bit 2 high marks a read. While the port is locked, ROM data reaches the bus unchanged.

To open the port, software sends a fixed 64-bit key as a run of write accesses, one key bit per access. A read access while locked brings the key comparison back to its first bit. Once the whole key has matched, exactly 64 accesses follow, and together they move the full register file serially.

- Each read returns the next register bit on data bit 0.
- Each write shifts in the next bit.

After the 64th access the port locks again. The parallel register contents come in on `regs_in` and are sampled when the key completes. A fully written image leaves on `regs_out`, marked by a one-cycle `regs_wr` pulse.

Top module: `pcu_unlock`

## Requirements
- R1: After synchronous active-high reset the port is locked, `regs_wr` is 0 and `bus_q` equals `rom_q`.
- R2: An access is taken on the clock where `sel` is high after being low. `addr[2]`=0 makes it a write whose data bit is `addr[0]`, and `addr[2]`=1 makes it a read.
- R3: The key is 64 bits, sent as bytes 0xC5, 0x3A, 0xA3, 0x5C, 0xC5, 0x3A, 0xA3, 0x5C in that order, each byte LSB first. The port unlocks on the write that matches the 64th key bit, and only then.
- R4: While locked, a write whose bit differs from the expected key bit sends the comparison back to key bit 0.
- R5: While locked, a read access sends the comparison back to key bit 0.
- R6: While the port is locked, `bus_q` equals `rom_q` on every bit.
- R7: `regs_in` is sampled on the access that completes the key. The k-th unlocked access carries register bit k, which is bit k%8 of byte k/8 (byte b is `regs_in[8b+7:8b]`). An unlocked read drives that bit on `bus_q[0]` from the clock after its access edge until `sel` falls. `bus_q[7:1]` always follows `rom_q[7:1]`.
- R8: An unlocked write loads `addr[0]` as register bit k, in the same order. When all 64 accesses of a session are writes, `regs_wr` pulses for one cycle after the 64th, with `regs_out` bit k equal to the k-th written bit.
- R9: A session that contains any read commits nothing. Its reads still return the sampled bits in order, and bits already written in that session do not disturb them.
- R10: After the 64th access of a session the port is locked again, and the next read passes ROM data through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | ROM chip select, active high, synchronous to clk |
| addr | input | 3 | Low ROM address bits: bit 0 is the data bit, bit 2 is the active-low write strobe |
| rom_q | input | 8 | Data from the ROM |
| bus_q | output | 8 | Data toward the bus |
| regs_in | input | 64 | Parallel image of the clock registers, byte b in bits 8b+7:8b |
| regs_out | output | 64 | Written register image, valid while regs_wr is high |
| regs_wr | output | 1 | One-cycle commit pulse after a full write session |

## Verification
The bench attacks the key comparison from both sides.
- A wrong bit in the middle of the key, followed by the rest of the key: a design that skipped the bit or kept its place would unlock.
- A dummy read after a key prefix: a design that ignored it would unlock when the remaining bits arrive.

Unlocked reads run over all 64 positions, against ROM patterns that change, and `regs_in` changes after the unlock. This exposes swapped byte or bit order, an off-by-one shift and a register image that is not held after the unlock edge.

A session of writes only, and then a session mixing writes and reads, show whether a mixed session wrongly commits and whether the port locks again after 64 accesses.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int KEY_BITS = 64;
    // byte 0 sits in bits 7:0; bits go out LSB first
    localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef struct packed {
        logic sel;       // chip select, one clock late
        logic open;      // transfer phase active
        logic hold;      // substituting data bit 0
        logic hold_bit;  // register bit shown during a read
    } top_st_t;

endpackage

// File: rtl/pcu_key_match.sv
module pcu_key_match #(
    parameter int                    KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0]   KEY      = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic step_wr,
    input  logic step_rd,
    input  logic bit_in,
    output logic hit
);
    localparam int PW = $clog2(KEY_BITS);
    localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (step_rd) begin
            st_d.ptr = '0;
        end else if (step_wr) begin
            if (bit_in == KEY[st_q.ptr]) begin
                if (st_q.ptr == LAST) begin
                    hit      = 1'b1;
                    st_d.ptr = '0;
                end else begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end else begin
                st_d.ptr = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/pcu_xfer_shift.sv
module pcu_xfer_shift #(
    parameter int NBITS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NBITS-1:0] snap,
    input  logic             step,
    input  logic             is_wr,
    input  logic             bit_in,
    output logic             cur_bit,
    output logic             done,
    output logic [NBITS-1:0] regs_out,
    output logic             regs_wr
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    typedef struct packed {
        logic [NBITS-1:0] shreg;
        logic [CW-1:0]    cnt;
        logic             wr_all;
        logic             commit;
    } xf_st_t;

    xf_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        done        = 1'b0;
        if (load) begin
            st_d.shreg  = snap;
            st_d.cnt    = '0;
            st_d.wr_all = 1'b1;
        end else if (step) begin
            // writes insert the new bit, reads rotate the old one back
            st_d.shreg  = {(is_wr ? bit_in : st_q.shreg[0]), st_q.shreg[NBITS-1:1]};
            st_d.wr_all = st_q.wr_all & is_wr;
            if (st_q.cnt == LAST) begin
                done        = 1'b1;
                st_d.cnt    = '0;
                st_d.commit = st_q.wr_all & is_wr;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cur_bit  = st_q.shreg[0];
    assign regs_out = st_q.shreg;
    assign regs_wr  = st_q.commit;

endmodule

// File: rtl/pcu_data_mux.sv
module pcu_data_mux #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rom_q,
    input  logic          sub,
    input  logic          sub_bit,
    output logic [DW-1:0] bus_q
);
    always_comb begin
        bus_q = rom_q;
        if (sub) bus_q[0] = sub_bit;
    end
endmodule

// File: rtl/pcu_unlock.sv
module pcu_unlock #(
    parameter int DW      = 8,
    parameter int ADDR_W  = 3,
    parameter int DIN_BIT = 0,
    parameter int WRN_BIT = 2,
    parameter int NBYTES  = 8,
    localparam int NBITS  = NBYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]    rom_q,
    output logic [DW-1:0]    bus_q,
    input  logic [NBITS-1:0] regs_in,
    output logic [NBITS-1:0] regs_out,
    output logic             regs_wr
);
    import pcu_pkg::*;

    top_st_t st_d, st_q;
    logic acc, is_wr, bit_in, hit, done, cur_bit;
    logic unused_addr;

    assign unused_addr = ^addr;
    assign acc    = sel & ~st_q.sel;
    assign is_wr  = ~addr[WRN_BIT];
    assign bit_in = addr[DIN_BIT];

    pcu_key_match #(.KEY_BITS(KEY_BITS), .KEY(UNLOCK_KEY)) u_key (
        .clk     (clk),
        .rst     (rst),
        .step_wr (acc & ~st_q.open & is_wr),
        .step_rd (acc & ~st_q.open & ~is_wr),
        .bit_in  (bit_in),
        .hit     (hit)
    );

    pcu_xfer_shift #(.NBITS(NBITS)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .load     (hit),
        .snap     (regs_in),
        .step     (acc & st_q.open),
        .is_wr    (is_wr),
        .bit_in   (bit_in),
        .cur_bit  (cur_bit),
        .done     (done),
        .regs_out (regs_out),
        .regs_wr  (regs_wr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel;
        if (hit)       st_d.open = 1'b1;
        else if (done) st_d.open = 1'b0;
        if (!sel) begin
            st_d.hold = 1'b0;
        end else if (acc && st_q.open && !is_wr) begin
            st_d.hold     = 1'b1;
            st_d.hold_bit = cur_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    pcu_data_mux #(.DW(DW)) u_mux (
        .rom_q   (rom_q),
        .sub     (st_q.hold & sel),
        .sub_bit (st_q.hold_bit),
        .bus_q   (bus_q)
    );

endmodule

// File: rtl/pcu_unlock_chk.sv
module pcu_unlock_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] rom_q,
    input logic [DW-1:0] bus_q,
    input logic          regs_wr,
    input logic          open,
    input logic          hold,
    input logic          acc,
    input logic          is_wr
);
    // R6: locked and not finishing a read -> pure passthrough
    a_r6_locked_passthru: assert property (@(posedge clk) disable iff (rst)
        (!open && !hold) |-> (bus_q == rom_q));

    // R7: upper data bits never touched
    a_r7_upper_bits: assert property (@(posedge clk) disable iff (rst)
        bus_q[DW-1:1] == rom_q[DW-1:1]);

    // R8: commit is a single-cycle pulse
    a_r8_commit_pulse: assert property (@(posedge clk) disable iff (rst)
        regs_wr |=> !regs_wr);

    // R10: a commit only appears once the port has relocked
    a_r10_commit_relocked: assert property (@(posedge clk) disable iff (rst)
        regs_wr |-> !open);

    // R3: unlocking follows a write access
    a_r3_unlock_on_write: assert property (@(posedge clk) disable iff (rst)
        $rose(open) |-> $past(acc && is_wr));
endmodule

bind pcu_unlock pcu_unlock_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rom_q   (rom_q),
    .bus_q   (bus_q),
    .regs_wr (regs_wr),
    .open    (st_q.open),
    .hold    (st_q.hold),
    .acc     (acc),
    .is_wr   (is_wr)
);

// File: tb/pcu_unlock_bench.sv
module pcu_unlock_bench;
    localparam time CLK_PERIOD = 10;
    localparam logic [63:0] KEY_V = {8'h5C, 8'hA3, 8'h3A, 8'hC5, 8'h5C, 8'hA3, 8'h3A, 8'hC5};
    localparam logic [63:0] SNAP1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] SNAP2 = 64'h8421_F0E1_D2C3_B4A5;
    localparam logic [63:0] WDAT  = 64'hC3A5_0F96_1E2D_7B48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic [2:0]  addr = 3'b100;
    logic [7:0]  rom_q = 8'h00;
    logic [7:0]  bus_q;
    logic [63:0] regs_in = '0;
    logic [63:0] regs_out;
    logic        regs_wr;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [63:0] commit_q[$];
    event        smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_unlock u_pcu_unlock (
        .clk(clk), .rst(rst), .sel(sel), .addr(addr), .rom_q(rom_q),
        .bus_q(bus_q), .regs_in(regs_in), .regs_out(regs_out), .regs_wr(regs_wr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read monitor: pops expected bus values
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) chk("R7 scoreboard underflow", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), 64'(bus_q), 64'(exp_q.pop_front()));
        end
    end

    // commit monitor
    always @(negedge clk) begin
        if (!rst && regs_wr) begin
            n_commit++;
            if (commit_q.size() == 0) chk("R9 unexpected commit", 64'd1, 64'd0);
            else chk("R8 commit data", regs_out, commit_q.pop_front());
        end
    end

    task automatic access(input bit wr, input bit b, input logic [7:0] rom,
                          input bit is_chk, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr  = {~wr, 1'b0, b};
        rom_q = rom;
        sel   = 1'b1;
        if (is_chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        @(negedge clk);
        if (is_chk) ->smp_ev;
        #(CLK_PERIOD/4);
        sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_bit(input bit b);
        access(1'b1, b, 8'h00, 1'b0, 8'h00, "");
    endtask

    task automatic rd_chk(input logic [7:0] rom, input logic [7:0] exp, input string tag);
        access(1'b0, 1'b0, rom, 1'b1, exp, tag);
    endtask

    task automatic key_bits(input int from, input int upto);
        for (int i = from; i <= upto; i++) wr_bit(KEY_V[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rom_q = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset bus", 64'(bus_q), 64'h3C);
        chk("R1 reset regs_wr", 64'(regs_wr), 64'd0);

        rd_chk(8'hA6, 8'hA6, "R6 locked read");

        // R3 R7: unlock, read all 64 bits; regs_in moves afterwards
        regs_in = SNAP1;
        key_bits(0, 63);
        regs_in = ~SNAP1;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] r;
            r = 8'(i * 37 + 5);
            rd_chk(r, {r[7:1], SNAP1[i]}, "R2 R3 R7 unlocked read");
        end
        rd_chk(8'h81, 8'h81, "R10 relocked read");

        // R4: bad bit mid-key then the remainder
        key_bits(0, 19);
        wr_bit(~KEY_V[20]);
        key_bits(21, 63);
        rd_chk(8'h7E, 8'h7E, "R4 mismatch stays locked");

        // R5: dummy read mid-key resets comparison
        key_bits(0, 9);
        rd_chk(8'h19, 8'h19, "R5 locked read passthrough");
        key_bits(10, 63);
        rd_chk(8'hE4, 8'hE4, "R5 no unlock after reset");

        // R8: full write session
        key_bits(0, 63);
        commit_q.push_back(WDAT);
        for (int i = 0; i < 64; i++) wr_bit(WDAT[i]);
        repeat (3) @(negedge clk);
        chk("R8 commit seen", 64'(commit_q.size()), 64'd0);
        rd_chk(8'h5A, 8'h5A, "R10 relocked after writes");

        // R9: mixed session
        regs_in = SNAP2;
        key_bits(0, 63);
        for (int i = 0; i < 32; i++) wr_bit(WDAT[i]);
        for (int i = 0; i < 32; i++) begin
            logic [7:0] r;
            r = 8'(i * 11 + 200);
            rd_chk(r, {r[7:1], SNAP2[32 + i]}, "R9 mixed read");
        end
        repeat (3) @(negedge clk);
        chk("R9 no commit from mixed session", 64'(n_commit), 64'd1);
        rd_chk(8'hC7, 8'hC7, "R10 relocked after mixed");

        repeat (4) @(negedge clk);
        chk("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule